// File: doc/BRIEF.md
# Bidirectional Video Port Bank Router

This block sits between two banks of pad-side video ports and a four-channel processing core. Each bank holds three wide ports and one narrow port. A direction setting chooses which bank carries samples into the core and which bank carries the core's results out. The other bank is read, never driven. A flag-output setting lets the input bank's three wide ports give up their top bit to carry the horizontal, vertical and field timing flags outward. Their lower bits stay inputs.

Samples are 10 bits wide on the core side. An 8-bit sample is held left-aligned, in bits 9..2. A format input chooses 10-bit or 8-bit packing. On the way out, the block places the sample at fixed bit positions inside the wider port words and clears every other bit. On the way in, it extracts the sample from the same positions and treats every bit outside them as zero.

The port enables come from registers and are driven by a small controller with three states:
- ST_UNCFG: after reset, nothing drives. On the first configuration write the controller goes to ST_DRIVE.
- ST_DRIVE: enables follow the configuration. A write that changes the direction goes to ST_TURN. A write that changes only the flag setting stays in ST_DRIVE.
- ST_TURN: every driver is off for one clock. The controller then returns to ST_DRIVE, or stays in ST_TURN if another write reverses the direction again.

A synchronous disable input forces every enable off.

Top module: `vpr_router`

## Requirements
- R1: While reset is asserted, every output enable of both banks is 0.
- R2: After reset, no enable is 1 until the first clock edge that samples cfg_wr high.
- R3: With direction 0, bank B data bits are driven and bank A data bits are not. Core input channel k (k=0..2 wide, k=3 narrow) is extracted from bank A port k.
- R4: With direction 1, the roles are swapped. Bank A data bits are driven, bank B data bits are not, and the core inputs are extracted from bank B.
- R5: A write that changes the direction yields exactly one clock with every enable 0. The new bank's enables turn on at the following edge. The two banks' data enables are never 1 in consecutive cycles across a swap.
- R6: With the flag setting 1, bit 12 of each of the input bank's three wide ports is enabled and carries hvf_flags[0], [1] and [2] respectively. The lower bits of those ports, and the whole narrow port, stay undriven.
- R7: port_dis is sampled at the clock edge. From the first edge that samples it high, every enable is 0. The enables return at the first edge that samples it low.
- R8: In 10-bit format (fmt_8b=0), an output port word holds the sample in bits 9..0, with all bits above cleared: 12..10 on a wide port, 10 on the narrow port.
- R9: In 8-bit format (fmt_8b=1), an output port word holds sample bits 9..2 in bits 9..2, with bits 1..0 and all bits above 9 cleared.
- R10: Input extraction uses port bits 9..0 in 10-bit format, and bits 9..2 with bits 1..0 returned as 0 in 8-bit format. Other port bits have no effect on core_in.
- R11: A write that keeps the direction but changes the flag setting updates the enables at the next edge with no all-off cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Loads cfg_dir and cfg_hvf at the clock edge |
| cfg_dir | input | 1 | 0: bank A in, bank B out; 1: swapped |
| cfg_hvf | input | 1 | 1: timing flags on bit 12 of the input bank's wide ports |
| port_dis | input | 1 | 1: all ports undriven (synchronous) |
| fmt_8b | input | 1 | 0: 10-bit packing, 1: 8-bit packing |
| hvf_flags | input | 3 | Horizontal, vertical, field flags |
| core_out | input | 4x10 | Core result samples per channel |
| core_in | output | 4x10 | Samples extracted for the core |
| pa_wide_i | input | 3x13 | Bank A wide port pad inputs |
| pa_nar_i | input | 11 | Bank A narrow port pad input |
| pa_wide_o | output | 3x13 | Bank A wide port pad outputs |
| pa_nar_o | output | 11 | Bank A narrow port pad output |
| pa_wide_oe_lo | output | 3 | Bank A wide ports, enable for bits 11..0 |
| pa_wide_oe_hi | output | 3 | Bank A wide ports, enable for bit 12 |
| pa_nar_oe | output | 1 | Bank A narrow port enable |
| pb_wide_i | input | 3x13 | Bank B wide port pad inputs |
| pb_nar_i | input | 11 | Bank B narrow port pad input |
| pb_wide_o | output | 3x13 | Bank B wide port pad outputs |
| pb_nar_o | output | 11 | Bank B narrow port pad output |
| pb_wide_oe_lo | output | 3 | Bank B wide ports, enable for bits 11..0 |
| pb_wide_oe_hi | output | 3 | Bank B wide ports, enable for bit 12 |
| pb_nar_oe | output | 1 | Bank B narrow port enable |

## Verification
Some properties are checked by assertions on every cycle:
- no enable rises before the first configuration write;
- a bank's data enables are never followed in the next cycle by the other bank's;
- a sampled disable leaves nothing driven;
- a flag-only bit-12 enable occurs only while the other bank drives data.

The bench scenarios are needed for the rest:
- the exact one-clock gap on a swap and its absence on a flag-only change;
- the flag values on bit 12;
- the bit-exact packing and extraction in both formats, swept over every 10-bit sample value in both directions.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
    localparam int WIDE_W       = 13;
    localparam int NAR_W        = 11;
    localparam int SMP_W        = 10;
    localparam int NARROW_SMP_W = 8;
    localparam int NUM_WIDE     = 3;
    localparam int NUM_CH       = NUM_WIDE + 1;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_DRIVE = 2'd1,
        ST_TURN  = 2'd2
    } vpr_state_e;
endpackage

// File: rtl/vpr_pack.sv
module vpr_pack #(
    parameter int PORT_W       = 13,
    parameter int SMP_W        = 10,
    parameter int NARROW_SMP_W = 8
) (
    input  logic [SMP_W-1:0]  smp,
    input  logic              fmt_8b,
    output logic [PORT_W-1:0] word
);
    localparam int LOW_Z = SMP_W - NARROW_SMP_W;
    localparam int HI_Z  = PORT_W - SMP_W;

    always_comb begin
        if (fmt_8b)
            word = {{HI_Z{1'b0}}, smp[SMP_W-1:LOW_Z], {LOW_Z{1'b0}}};
        else
            word = {{HI_Z{1'b0}}, smp};
    end
endmodule

// File: rtl/vpr_unpack.sv
module vpr_unpack #(
    parameter int PORT_W       = 13,
    parameter int SMP_W        = 10,
    parameter int NARROW_SMP_W = 8
) (
    input  logic [PORT_W-1:0] word,
    input  logic              fmt_8b,
    output logic [SMP_W-1:0]  smp
);
    localparam int LOW_Z = SMP_W - NARROW_SMP_W;

    logic unused_hi;
    assign unused_hi = ^word[PORT_W-1:SMP_W];

    always_comb begin
        if (fmt_8b)
            smp = {word[SMP_W-1:LOW_Z], {LOW_Z{1'b0}}};
        else
            smp = word[SMP_W-1:0];
    end
endmodule

// File: rtl/vpr_ctrl.sv
module vpr_ctrl
    import vpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_dir,
    input  logic cfg_hvf,
    input  logic port_dis,
    output logic dir_q,
    output logic a_data_en,
    output logic b_data_en,
    output logic a_flag_en,
    output logic b_flag_en
);
    vpr_state_e state, state_nx;
    logic hvf_q;
    logic dis_q;
    logic swap_req;

    assign swap_req = cfg_wr && (cfg_dir != dir_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNCFG: if (cfg_wr)   state_nx = ST_DRIVE;
            ST_DRIVE: if (swap_req) state_nx = ST_TURN;
            ST_TURN:  state_nx = swap_req ? ST_TURN : ST_DRIVE;
            default:  state_nx = ST_UNCFG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_UNCFG;
            dir_q <= 1'b0;
            hvf_q <= 1'b0;
            dis_q <= 1'b1;
        end else begin
            state <= state_nx;
            dis_q <= port_dis;
            if (cfg_wr) begin
                dir_q <= cfg_dir;
                hvf_q <= cfg_hvf;
            end
        end
    end

    always_comb begin
        a_data_en = 1'b0;
        b_data_en = 1'b0;
        a_flag_en = 1'b0;
        b_flag_en = 1'b0;
        unique case (state)
            ST_DRIVE: begin
                if (!dis_q) begin
                    a_data_en = dir_q;
                    b_data_en = !dir_q;
                    a_flag_en = !dir_q && hvf_q;
                    b_flag_en = dir_q && hvf_q;
                end
            end
            ST_UNCFG, ST_TURN: ;
            default: ;
        endcase
    end

    a_r11_flag_only_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DRIVE && $past(cfg_wr) && $past(cfg_dir) == $past(dir_q))
        |-> (state == ST_DRIVE));
endmodule

// File: rtl/vpr_router.sv
module vpr_router
    import vpr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic                              cfg_dir,
    input  logic                              cfg_hvf,
    input  logic                              port_dis,
    input  logic                              fmt_8b,
    input  logic [NUM_WIDE-1:0]               hvf_flags,
    input  logic [NUM_CH-1:0][SMP_W-1:0]      core_out,
    output logic [NUM_CH-1:0][SMP_W-1:0]      core_in,
    input  logic [NUM_WIDE-1:0][WIDE_W-1:0]   pa_wide_i,
    input  logic [NAR_W-1:0]                  pa_nar_i,
    output logic [NUM_WIDE-1:0][WIDE_W-1:0]   pa_wide_o,
    output logic [NAR_W-1:0]                  pa_nar_o,
    output logic [NUM_WIDE-1:0]               pa_wide_oe_lo,
    output logic [NUM_WIDE-1:0]               pa_wide_oe_hi,
    output logic                              pa_nar_oe,
    input  logic [NUM_WIDE-1:0][WIDE_W-1:0]   pb_wide_i,
    input  logic [NAR_W-1:0]                  pb_nar_i,
    output logic [NUM_WIDE-1:0][WIDE_W-1:0]   pb_wide_o,
    output logic [NAR_W-1:0]                  pb_nar_o,
    output logic [NUM_WIDE-1:0]               pb_wide_oe_lo,
    output logic [NUM_WIDE-1:0]               pb_wide_oe_hi,
    output logic                              pb_nar_oe
);
    logic dir_q;
    logic a_data_en, b_data_en, a_flag_en, b_flag_en;

    vpr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dir   (cfg_dir),
        .cfg_hvf   (cfg_hvf),
        .port_dis  (port_dis),
        .dir_q     (dir_q),
        .a_data_en (a_data_en),
        .b_data_en (b_data_en),
        .a_flag_en (a_flag_en),
        .b_flag_en (b_flag_en)
    );

    for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
        logic [WIDE_W-1:0] packed_w;
        logic [WIDE_W-1:0] in_sel;
        logic [WIDE_W-1:0] flag_w;

        vpr_pack #(.PORT_W(WIDE_W), .SMP_W(SMP_W), .NARROW_SMP_W(NARROW_SMP_W)) u_pack (
            .smp(core_out[k]), .fmt_8b(fmt_8b), .word(packed_w));

        assign in_sel = dir_q ? pb_wide_i[k] : pa_wide_i[k];

        vpr_unpack #(.PORT_W(WIDE_W), .SMP_W(SMP_W), .NARROW_SMP_W(NARROW_SMP_W)) u_unpack (
            .word(in_sel), .fmt_8b(fmt_8b), .smp(core_in[k]));

        assign flag_w = {hvf_flags[k], {(WIDE_W-1){1'b0}}};

        assign pa_wide_o[k]     = dir_q ? packed_w : flag_w;
        assign pb_wide_o[k]     = dir_q ? flag_w   : packed_w;
        assign pa_wide_oe_lo[k] = a_data_en;
        assign pb_wide_oe_lo[k] = b_data_en;
        assign pa_wide_oe_hi[k] = a_data_en | a_flag_en;
        assign pb_wide_oe_hi[k] = b_data_en | b_flag_en;
    end

    logic [NAR_W-1:0] nar_packed;
    logic [NAR_W-1:0] nar_sel;

    vpr_pack #(.PORT_W(NAR_W), .SMP_W(SMP_W), .NARROW_SMP_W(NARROW_SMP_W)) u_pack_nar (
        .smp(core_out[NUM_WIDE]), .fmt_8b(fmt_8b), .word(nar_packed));

    assign nar_sel = dir_q ? pb_nar_i : pa_nar_i;

    vpr_unpack #(.PORT_W(NAR_W), .SMP_W(SMP_W), .NARROW_SMP_W(NARROW_SMP_W)) u_unpack_nar (
        .word(nar_sel), .fmt_8b(fmt_8b), .smp(core_in[NUM_WIDE]));

    assign pa_nar_o  = dir_q ? nar_packed : '0;
    assign pb_nar_o  = dir_q ? '0 : nar_packed;
    assign pa_nar_oe = a_data_en;
    assign pb_nar_oe = b_data_en;

    logic cfg_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_seen <= 1'b0;
        else if (cfg_wr) cfg_seen <= 1'b1;
    end

    logic any_a_lo, any_b_lo, any_oe;
    assign any_a_lo = (|pa_wide_oe_lo) | pa_nar_oe;
    assign any_b_lo = (|pb_wide_oe_lo) | pb_nar_oe;
    assign any_oe   = any_a_lo | any_b_lo | (|pa_wide_oe_hi) | (|pb_wide_oe_hi);

    a_r2_quiet_before_config: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_seen |-> !any_oe);

    a_r5_gap_a_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_a_lo) |-> !any_b_lo);

    a_r5_gap_b_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_b_lo) |-> !any_a_lo);

    a_r7_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
        $past(port_dis) |-> !any_oe);

    a_r6_flags_with_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pa_wide_oe_hi) && !any_a_lo) |-> any_b_lo);
endmodule

// File: tb/tb_vpr_router.sv
module tb_vpr_router;
    import vpr_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_dir = 1'b0, cfg_hvf = 1'b0, port_dis = 1'b0, fmt_8b = 1'b0;
    logic [NUM_WIDE-1:0] hvf_flags = '0;
    logic [NUM_CH-1:0][SMP_W-1:0] core_out = '0;
    logic [NUM_CH-1:0][SMP_W-1:0] core_in;
    logic [NUM_WIDE-1:0][WIDE_W-1:0] pa_wide_i = '0, pb_wide_i = '0;
    logic [NAR_W-1:0] pa_nar_i = '0, pb_nar_i = '0;
    logic [NUM_WIDE-1:0][WIDE_W-1:0] pa_wide_o, pb_wide_o;
    logic [NAR_W-1:0] pa_nar_o, pb_nar_o;
    logic [NUM_WIDE-1:0] pa_wide_oe_lo, pa_wide_oe_hi, pb_wide_oe_lo, pb_wide_oe_hi;
    logic pa_nar_oe, pb_nar_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpr_router dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int oe_a();
        return int'({pa_wide_oe_lo, pa_wide_oe_hi, pa_nar_oe});
    endfunction
    function automatic int oe_b();
        return int'({pb_wide_oe_lo, pb_wide_oe_hi, pb_nar_oe});
    endfunction

    function automatic int exp_pack(input int v, input bit f8);
        return f8 ? (v / 4) * 4 : v;
    endfunction
    function automatic int exp_unpack(input int w, input bit f8);
        return f8 ? ((w % 1024) / 4) * 4 : (w % 1024);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write_cfg(input bit d, input bit h);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dir = d; cfg_hvf = h;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic sweep(input bit d, input string req_map);
        for (int f = 0; f < 2; f++) begin
            fmt_8b = f[0];
            for (int v = 0; v < 1024; v++) begin
                for (int k = 0; k < NUM_CH; k++) core_out[k] = SMP_W'((v + k * 97) % 1024);
                for (int k = 0; k < NUM_WIDE; k++) begin
                    pa_wide_i[k] = WIDE_W'((v * 13 + k * 511) % 8192);
                    pb_wide_i[k] = WIDE_W'((v * 29 + k * 733 + 77) % 8192);
                end
                pa_nar_i = NAR_W'((v * 7 + 3) % 2048);
                pb_nar_i = NAR_W'((v * 11 + 1500) % 2048);
                #1;
                for (int k = 0; k < NUM_WIDE; k++) begin
                    int wi = d ? int'(pb_wide_i[k]) : int'(pa_wide_i[k]);
                    int wo = d ? int'(pa_wide_o[k]) : int'(pb_wide_o[k]);
                    check({req_map, " R10 core_in wide"}, int'(core_in[k]), exp_unpack(wi, f[0]));
                    check(f[0] ? "R9 wide pack" : "R8 wide pack", wo,
                          exp_pack((v + k * 97) % 1024, f[0]));
                end
                begin
                    int ni = d ? int'(pb_nar_i) : int'(pa_nar_i);
                    int no = d ? int'(pa_nar_o) : int'(pb_nar_o);
                    check({req_map, " R10 core_in narrow"}, int'(core_in[NUM_WIDE]), exp_unpack(ni, f[0]));
                    check(f[0] ? "R9 narrow pack" : "R8 narrow pack", no,
                          exp_pack((v + NUM_WIDE * 97) % 1024, f[0]));
                end
            end
        end
        fmt_8b = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        check("R1 bank A oe in reset", oe_a(), 0);
        check("R1 bank B oe in reset", oe_b(), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) begin
            step();
            check("R2 bank A oe before config", oe_a(), 0);
            check("R2 bank B oe before config", oe_b(), 0);
        end

        write_cfg(1'b0, 1'b0);
        check("R3 bank A undriven", oe_a(), 0);
        check("R3 bank B driven", oe_b(), 7'h7F);
        sweep(1'b0, "R3");

        write_cfg(1'b0, 1'b1);
        check("R11 bank B still driven", oe_b(), 7'h7F);
        check("R6 bank A lo off", int'(pa_wide_oe_lo), 0);
        check("R6 bank A narrow off", int'(pa_nar_oe), 0);
        check("R6 bank A hi on", int'(pa_wide_oe_hi), 7);
        for (int p = 0; p < 8; p++) begin
            hvf_flags = 3'(p);
            #1;
            for (int k = 0; k < NUM_WIDE; k++)
                check("R6 flag bit", int'(pa_wide_o[k][WIDE_W-1]), (p >> k) & 1);
        end

        write_cfg(1'b1, 1'b1);
        check("R5 gap bank A", oe_a(), 0);
        check("R5 gap bank B", oe_b(), 0);
        step();
        check("R4 bank A lo on", int'(pa_wide_oe_lo), 7);
        check("R4 bank A narrow on", int'(pa_nar_oe), 1);
        check("R4 bank B lo off", int'(pb_wide_oe_lo), 0);
        check("R6 bank B hi on", int'(pb_wide_oe_hi), 7);
        hvf_flags = 3'b101;
        #1;
        for (int k = 0; k < NUM_WIDE; k++)
            check("R6 flag bit bank B", int'(pb_wide_o[k][WIDE_W-1]), (5 >> k) & 1);
        sweep(1'b1, "R4");

        @(negedge clk); port_dis = 1'b1;
        #1;
        check("R7 still driven before edge", int'(pa_wide_oe_lo), 7);
        step();
        check("R7 bank A off", oe_a(), 0);
        check("R7 bank B off", oe_b(), 0);
        @(negedge clk); port_dis = 1'b0;
        step();
        check("R7 bank A back", int'(pa_wide_oe_lo), 7);

        write_cfg(1'b0, 1'b0);
        check("R5 gap back A", oe_a(), 0);
        check("R5 gap back B", oe_b(), 0);
        step();
        check("R5 bank B on after gap", oe_b(), 7'h7F);
        check("R3 bank A off after swap", oe_a(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule